// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a three-wire serial slave that configures a bank of 10-bit control registers. The host drives a serial clock, a data line and an active-low load line. Each 16-bit word, sent most significant bit first, carries a direction flag, a 5-bit register address and a 10-bit payload. Several words may follow each other while load stays low. A pin chooses which serial clock edge captures the data.

A read is split into two phases. The request word names the register. The response goes out on a single read-back line during the next 16 serial clocks, with the output enable raised only while the response is shifting. The register contents drive the block's outputs directly. A self-clearing bit in the control register restores the whole bank to its defaults. All serial inputs are brought into the fast system clock domain by synchronisers and sampled there, so the serial clock must be several times slower than the system clock.

Top module: `serial_reg_port`

## Requirements
- R1: A word is 16 bits, MSB first: bit 15 is the direction (0 write, 1 read), bits 14..10 the address and bits 9..0 the payload. A write word stores the payload into the register at that address, and the register's output port shows it.
- R2: Bits are taken only while load is low, and several words may follow under one load-low period. Raising load before the 16th bit discards the partial word, and the next word is framed from its first bit.
- R3: With the polarity pin at 1, data is captured on rising serial clock edges and the falling edge is idle. With the pin at 0, the roles of the two edges swap.
- R4: The payload of a read word is ignored and changes no register. If load is still low, the response MSB is driven after the opposite edge that follows capture edge 17 of the request, so the host reads it at capture edge 18. If load is high by then, the MSB is driven as soon as load next goes low.
- R5: The response word has bits 15..10 at zero and the register contents in bits 9..0. The read-back line changes only on the non-capture edge.
- R6: Writing address 0 with bit 0 set returns every register to its default. Bit 0 of address 0 always reads 0.
- R7: While the active-low reset is asserted, all registers take their defaults. Address 0 defaults to 0x380, address 9 to 0x010 and every other register to 0.
- R8: The read-back enable is high only while a response is shifting. It falls after the host has captured the 16th response bit, or when load rises.
- R9: Addresses 4, 5 and 11..31 hold nothing. Writes to them change no register, and reads from them return zero.
- R10: When two reads are sent back to back, the second response follows the first with no gap, and the enable stays high across the join.
- R11: Registers still accept writes after bit 9 of address 0 (the standby control) has been cleared.
- The register map: 0 control, 1 gain, 2 and 3 user DAC codes, 6 black-level reference, 7 blanking level, 8 signal polarity, 9 timing 1, 10 timing 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock |
| sdin_i | input | 1 | Serial data from host |
| sload_ni | input | 1 | Active-low transfer window |
| sclk_pol_i | input | 1 | 1: capture on rising edge, 0: capture on falling edge |
| sdo_o | output | 1 | Read-back data |
| sdo_oe_o | output | 1 | Read-back driver enable |
| ctrl_o | output | 10 | Control register (address 0) |
| gain_o | output | 10 | Gain code (address 1) |
| dac1_o | output | 10 | User DAC 1 register (address 2) |
| dac2_o | output | 10 | User DAC 2 register (address 3) |
| black_ref_o | output | 10 | Black-level reference (address 6) |
| blank_lvl_o | output | 10 | Blanking output level (address 7) |
| sig_pol_o | output | 10 | Signal polarity register (address 8) |
| timing1_o | output | 10 | Timing register 1 (address 9) |
| timing2_o | output | 10 | Timing register 2 (address 10) |

## Verification
Two events can land on the same non-capture edge: the release after the last bit of one response, and the start of the next pending response. The bench provokes this by sending two read words back to back under one load-low period. It then checks that the enable stays high across all 32 response bit times and that both words come out intact, one after the other. A second collision puts a write of the register being read in the word that follows the read. There the response must carry the value latched at its start.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int REG_W     = 10;
  localparam int ADDR_W    = 5;
  localparam int NUM_SLOTS = 9;
  localparam int CTRL_SLOT = 0;
  localparam int SOFT_RST_BIT = 0;

  function automatic int slot_addr(input int s);
    case (s)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 3;
      4: return 6;
      5: return 7;
      6: return 8;
      7: return 9;
      default: return 10;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] slot_default(input int s);
    logic [REG_W-1:0] v;
    v = '0;
    if (s == CTRL_SLOT) begin
      v[7] = 1'b1;  // calibration enable
      v[8] = 1'b1;  // pin clamp
      v[9] = 1'b1;  // standby-not
    end
    if (s == 7) v[4] = 1'b1;  // timing 1 bypass
    return v;
  endfunction

  function automatic bit is_mapped(input int a);
    for (int s = 0; s < NUM_SLOTS; s++)
      if (slot_addr(s) == a) return 1'b1;
    return 1'b0;
  endfunction
endpackage

// File: rtl/sp_edge_sync.sv
module sp_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sdin_i,
  input  logic sload_ni,
  input  logic pol_i,
  output logic sample_o,
  output logic launch_o,
  output logic data_o,
  output logic load_low_o,
  output logic load_fall_o,
  output logic load_rise_o
);
  localparam logic [3:0] SYNC_RST = 4'b0100;

  logic [3:0] sync_q [SYNC_STAGES];
  logic       sclk_d, load_low_d;
  logic       sclk_s, rise, fall, pol_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= SYNC_RST;
      sclk_d     <= 1'b0;
      load_low_d <= 1'b0;
    end else begin
      sync_q[0] <= {pol_i, sload_ni, sdin_i, sclk_i};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      sclk_d     <= sclk_s;
      load_low_d <= load_low_o;
    end
  end

  assign sclk_s      = sync_q[SYNC_STAGES-1][0];
  assign data_o      = sync_q[SYNC_STAGES-1][1];
  assign load_low_o  = ~sync_q[SYNC_STAGES-1][2];
  assign pol_s       = sync_q[SYNC_STAGES-1][3];
  assign rise        = sclk_s & ~sclk_d;
  assign fall        = ~sclk_s & sclk_d;
  assign sample_o    = load_low_o & (pol_s ? rise : fall);
  assign launch_o    = load_low_o & (pol_s ? fall : rise);
  assign load_fall_o = load_low_o & ~load_low_d;
  assign load_rise_o = ~load_low_o & load_low_d;
endmodule

// File: rtl/sp_frame_rx.sv
module sp_frame_rx #(
  parameter int FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sample_i,
  input  logic               data_i,
  input  logic               load_low_i,
  output logic               frame_valid_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int CW = $clog2(FRAME_W);
  localparam logic [CW-1:0] LAST = CW'(FRAME_W - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q         <= '0;
      frame_o       <= '0;
      frame_valid_o <= 1'b0;
    end else begin
      frame_valid_o <= sample_i && (cnt_q == LAST);
      if (!load_low_i) begin
        cnt_q <= '0;  // partial word dropped
      end else if (sample_i) begin
        frame_o <= {frame_o[FRAME_W-2:0], data_i};
        cnt_q   <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sp_reg_bank.sv
module sp_reg_bank #(
  parameter int DATA_W    = sp_pkg::REG_W,
  parameter int ADDR_W    = sp_pkg::ADDR_W,
  parameter int NUM_SLOTS = sp_pkg::NUM_SLOTS
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [ADDR_W-1:0]                wr_addr_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  input  logic [ADDR_W-1:0]                rd_addr_i,
  output logic [DATA_W-1:0]                rd_data_o,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0] regs_o
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(sp_pkg::slot_addr(sp_pkg::CTRL_SLOT));

  logic soft_rst;
  assign soft_rst = wr_en_i && (wr_addr_i == CTRL_A) && wr_data_i[sp_pkg::SOFT_RST_BIT];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(sp_pkg::slot_addr(s));
    localparam logic [DATA_W-1:0] SLOT_D = DATA_W'(sp_pkg::slot_default(s));
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] wval;

    if (s == sp_pkg::CTRL_SLOT) begin : g_ctrl
      assign wval = {wr_data_i[DATA_W-1:1], 1'b0};
    end else begin : g_plain
      assign wval = wr_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             q <= SLOT_D;
      else if (soft_rst)                       q <= SLOT_D;
      else if (wr_en_i && wr_addr_i == SLOT_A) q <= wval;
    end

    assign regs_o[s] = q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (rd_addr_i == ADDR_W'(sp_pkg::slot_addr(s))) rd_data_o = regs_o[s];
  end
endmodule

// File: rtl/sp_readback_tx.sv
module sp_readback_tx #(
  parameter int DATA_W  = sp_pkg::REG_W,
  parameter int ADDR_W  = sp_pkg::ADDR_W,
  parameter int FRAME_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              launch_i,
  input  logic              load_fall_i,
  input  logic              load_rise_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int LW = $clog2(FRAME_W + 1);
  localparam logic [LW-1:0] FULL = LW'(FRAME_W);

  logic               pending_q, seen_q, driving_q, armed_q;
  logic [LW-1:0]      left_q;
  logic [FRAME_W-1:0] shreg_q;
  logic               start, shift_next;

  // start wins over release when both hit one non-capture edge
  assign start      = pending_q && ((seen_q && launch_i) || load_fall_i);
  assign shift_next = driving_q && armed_q && launch_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      seen_q    <= 1'b0;
      driving_q <= 1'b0;
      armed_q   <= 1'b0;
      left_q    <= '0;
      shreg_q   <= '0;
      rd_addr_o <= '0;
    end else begin
      if (sample_i && pending_q) seen_q <= 1'b1;
      if (load_rise_i)           seen_q <= 1'b0;
      if (start) begin
        pending_q <= 1'b0;
        seen_q    <= 1'b0;
      end
      if (req_valid_i) begin
        pending_q <= 1'b1;
        seen_q    <= 1'b0;
        rd_addr_o <= req_addr_i;
      end

      if (sample_i && driving_q) armed_q <= 1'b1;
      if (start) begin
        shreg_q   <= FRAME_W'(rd_data_i);
        left_q    <= FULL;
        driving_q <= 1'b1;
        armed_q   <= 1'b0;
      end else if (shift_next) begin
        armed_q <= 1'b0;
        if (left_q == LW'(1)) begin
          driving_q <= 1'b0;
        end else begin
          shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
          left_q  <= left_q - 1'b1;
        end
      end
      if (load_rise_i) begin
        driving_q <= 1'b0;
        armed_q   <= 1'b0;
      end
    end
  end

  assign sdo_o    = driving_q & shreg_q[FRAME_W-1];
  assign sdo_oe_o = driving_q;
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port #(
  parameter int DATA_W      = sp_pkg::REG_W,
  parameter int ADDR_W      = sp_pkg::ADDR_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdin_i,
  input  logic              sload_ni,
  input  logic              sclk_pol_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] gain_o,
  output logic [DATA_W-1:0] dac1_o,
  output logic [DATA_W-1:0] dac2_o,
  output logic [DATA_W-1:0] black_ref_o,
  output logic [DATA_W-1:0] blank_lvl_o,
  output logic [DATA_W-1:0] sig_pol_o,
  output logic [DATA_W-1:0] timing1_o,
  output logic [DATA_W-1:0] timing2_o
);
  localparam int FRAME_W   = 1 + ADDR_W + DATA_W;
  localparam int NUM_SLOTS = sp_pkg::NUM_SLOTS;

  logic sample_w, launch_w, data_w, load_low_w, load_fall_w, load_rise_w;
  logic frame_valid_w;
  logic [FRAME_W-1:0] frame_w;
  logic wr_en_w, req_valid_w;
  logic [ADDR_W-1:0] wr_addr_w, rd_addr_w;
  logic [DATA_W-1:0] wr_data_w, rd_data_w;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] regs_w;

  sp_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sclk_i, .sdin_i, .sload_ni,
    .pol_i(sclk_pol_i),
    .sample_o(sample_w), .launch_o(launch_w), .data_o(data_w),
    .load_low_o(load_low_w), .load_fall_o(load_fall_w), .load_rise_o(load_rise_w)
  );

  sp_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk_i, .rst_ni,
    .sample_i(sample_w), .data_i(data_w), .load_low_i(load_low_w),
    .frame_valid_o(frame_valid_w), .frame_o(frame_w)
  );

  assign wr_en_w     = frame_valid_w & ~frame_w[FRAME_W-1];
  assign req_valid_w = frame_valid_w &  frame_w[FRAME_W-1];
  assign wr_addr_w   = frame_w[FRAME_W-2 -: ADDR_W];
  assign wr_data_w   = frame_w[DATA_W-1:0];

  sp_reg_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_bank (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en_w), .wr_addr_i(wr_addr_w), .wr_data_i(wr_data_w),
    .rd_addr_i(rd_addr_w), .rd_data_o(rd_data_w), .regs_o(regs_w)
  );

  sp_readback_tx #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FRAME_W(FRAME_W)) u_tx (
    .clk_i, .rst_ni,
    .sample_i(sample_w), .launch_i(launch_w),
    .load_fall_i(load_fall_w), .load_rise_i(load_rise_w),
    .req_valid_i(req_valid_w), .req_addr_i(wr_addr_w),
    .rd_addr_o(rd_addr_w), .rd_data_i(rd_data_w),
    .sdo_o, .sdo_oe_o
  );

  assign ctrl_o      = regs_w[0];
  assign gain_o      = regs_w[1];
  assign dac1_o      = regs_w[2];
  assign dac2_o      = regs_w[3];
  assign black_ref_o = regs_w[4];
  assign blank_lvl_o = regs_w[5];
  assign sig_pol_o   = regs_w[6];
  assign timing1_o   = regs_w[7];
  assign timing2_o   = regs_w[8];
endmodule

// File: rtl/sp_port_checker.sv
module sp_port_checker #(
  parameter int DATA_W    = sp_pkg::REG_W,
  parameter int ADDR_W    = sp_pkg::ADDR_W,
  parameter int NUM_SLOTS = sp_pkg::NUM_SLOTS
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             sdo_o,
  input logic                             sdo_oe_o,
  input logic                             launch_w,
  input logic                             load_low_w,
  input logic                             wr_en_w,
  input logic [ADDR_W-1:0]                wr_addr_w,
  input logic [DATA_W-1:0]                wr_data_w,
  input logic [NUM_SLOTS-1:0][DATA_W-1:0] regs_w
);
  logic [NUM_SLOTS-1:0][DATA_W-1:0] defaults;
  always_comb
    for (int s = 0; s < NUM_SLOTS; s++) defaults[s] = DATA_W'(sp_pkg::slot_default(s));

  AST_DRIVER_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(load_low_w) |=> !sdo_oe_o);  // R8

  AST_SDO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_oe_o && $past(sdo_oe_o) && !$past(launch_w)) |-> $stable(sdo_o));  // R5

  AST_SOFT_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_w && wr_addr_w == '0 && wr_data_w[0]) |=> (regs_w == defaults));  // R6

  AST_RESERVED_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_w && !sp_pkg::is_mapped(int'(wr_addr_w))) |=> $stable(regs_w));  // R9

  AST_GAIN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_w && wr_addr_w == ADDR_W'(1)) |=> (regs_w[1] == $past(wr_data_w)));  // R1
endmodule

bind serial_reg_port sp_port_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
  .launch_w(launch_w), .load_low_w(load_low_w), .wr_en_w(wr_en_w),
  .wr_addr_w(wr_addr_w), .wr_data_w(wr_data_w), .regs_w(regs_w)
);

// File: tb/tb_serial_reg_port.sv
module tb_serial_reg_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdin = 1'b0, sload_n = 1'b1, pol = 1'b1;
  logic sdo, sdo_oe;
  logic [9:0] ctrl, gain, dac1, dac2, blk, blank, spol, t1, t2;

  always #2 clk = ~clk;

  serial_reg_port dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdin_i(sdin), .sload_ni(sload_n),
    .sclk_pol_i(pol), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .ctrl_o(ctrl), .gain_o(gain), .dac1_o(dac1), .dac2_o(dac2), .black_ref_o(blk),
    .blank_lvl_o(blank), .sig_pol_o(spol), .timing1_o(t1), .timing2_o(t2)
  );

  localparam logic [89:0] DEFS = {10'h380, 10'h0, 10'h0, 10'h0, 10'h0,
                                  10'h0, 10'h0, 10'h010, 10'h0};
  // {address, write payload, expected read-back}
  localparam logic [24:0] VEC [10] = '{
    {5'd1,  10'h2D0, 10'h2D0}, {5'd2,  10'h1AB, 10'h1AB},
    {5'd3,  10'h0FF, 10'h0FF}, {5'd6,  10'h040, 10'h040},
    {5'd7,  10'h3FF, 10'h3FF}, {5'd8,  10'h015, 10'h015},
    {5'd9,  10'h02A, 10'h02A}, {5'd10, 10'h155, 10'h155},
    {5'd4,  10'h3FF, 10'h000}, {5'd21, 10'h123, 10'h000}
  };
  localparam logic [15:0] FILL = 16'h1000;  // write to reserved address 4

  int n_checks = 0, n_err = 0;
  logic [15:0] frames [4];
  int nframes = 0;
  logic rx_sdo [80];
  logic rx_oe  [80];

  function automatic logic [89:0] all_regs();
    return {ctrl, gain, dac1, dac2, blk, blank, spol, t1, t2};
  endfunction

  function automatic logic [9:0] port_of(input logic [4:0] a);
    case (a)
      5'd0: return ctrl;   5'd1: return gain;  5'd2: return dac1;
      5'd3: return dac2;   5'd6: return blk;   5'd7: return blank;
      5'd8: return spol;   5'd9: return t1;    default: return t2;
    endcase
  endfunction

  function automatic logic [15:0] resp(input int k0);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[15-i] = rx_sdo[k0+i];
    return r;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [89:0] act, input logic [89:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_pol(input logic p);
    pol  = p;
    sclk = p ? 1'b0 : 1'b1;
    tick(8);
  endtask

  task automatic serial_run(input int nbits);
    sload_n = 1'b0;
    tick(8);
    for (int k = 0; k < nbits; k++) begin
      sdin = (k / 16 < nframes) ? frames[k/16][15 - (k % 16)] : 1'b0;
      tick(8);
      rx_sdo[k] = sdo;
      rx_oe[k]  = sdo_oe;
      sclk = pol ? 1'b1 : 1'b0;  // capture edge
      tick(8);
      sclk = pol ? 1'b0 : 1'b1;  // opposite edge
    end
    tick(8);
    sload_n = 1'b1;
    tick(8);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [89:0] snap;
    tick(5);
    check("R7 reset defaults", all_regs(), DEFS);
    check("R8 enable idle after reset", 90'(sdo_oe), 90'(0));
    rst_n = 1'b1;
    tick(5);

    // table: write, read (payload ignored), filler write to reserved address
    for (int i = 0; i < 10; i++) begin
      logic [4:0] a;
      logic [9:0] wd, ex;
      {a, wd, ex} = VEC[i];
      set_pol((i % 2) == 0);
      snap = all_regs();
      frames[0] = {1'b0, a, wd};
      frames[1] = {1'b1, a, ~wd};
      frames[2] = FILL;
      nframes = 3;
      serial_run(50);
      if (ex != 10'h0 || a inside {5'd0,5'd1,5'd2,5'd3,5'd6,5'd7,5'd8,5'd9,5'd10})
        check($sformatf("R1 R3 write port addr %0d pol %0d", a, pol), 90'(port_of(a)), 90'(wd));
      else
        check($sformatf("R9 reserved write addr %0d", a), all_regs(), snap);
      check($sformatf("R4 R5 R9 read-back addr %0d", a), 90'(resp(33)), 90'({6'b0, ex}));
      check("R8 enable low before response", 90'(rx_oe[32]), 90'(0));
      check("R8 enable high at first bit", 90'(rx_oe[33]), 90'(1));
      check("R8 enable low after last bit", 90'(rx_oe[49]), 90'(0));
    end

    // R2: partial word discarded, next word framed from its first bit
    set_pol(1'b1);
    frames[0] = {1'b0, 5'd1, 10'h0AA};
    nframes = 1;
    serial_run(7);
    check("R2 partial word ignored", 90'(gain), 90'(10'h2D0));
    serial_run(16);
    check("R2 full word after partial", 90'(gain), 90'(10'h0AA));

    // R4: load released after request, response starts at next load fall
    frames[0] = {1'b1, 5'd2, 10'h000};
    nframes = 1;
    serial_run(16);
    check("R8 no drive while load high", 90'(sdo_oe), 90'(0));
    frames[0] = FILL;
    serial_run(17);
    check("R4 deferred response", 90'(resp(0)), 90'({6'b0, 10'h1AB}));
    check("R8 deferred release", 90'(rx_oe[16]), 90'(0));

    // R10: back-to-back reads
    set_pol(1'b0);
    frames[0] = {1'b1, 5'd1, 10'h000};
    frames[1] = {1'b1, 5'd3, 10'h000};
    frames[2] = FILL;
    nframes = 3;
    serial_run(50);
    check("R10 first response", 90'(resp(17)), 90'({6'b0, 10'h0AA}));
    check("R10 second response", 90'(resp(33)), 90'({6'b0, 10'h0FF}));
    begin
      int gaps = 0;
      for (int k = 17; k < 49; k++) if (rx_oe[k] !== 1'b1) gaps++;
      check("R10 enable continuous", 90'(gaps), 90'(0));
    end

    // R5: write to the register under read lands after the snapshot
    frames[0] = {1'b1, 5'd6, 10'h000};
    frames[1] = {1'b0, 5'd6, 10'h2C3};
    frames[2] = FILL;
    serial_run(50);
    check("R5 snapshot at response start", 90'(resp(17)), 90'({6'b0, 10'h040}));
    check("R1 write during response", 90'(blk), 90'(10'h2C3));

    // R8: load rise aborts a running response
    set_pol(1'b1);
    frames[0] = {1'b1, 5'd3, 10'h000};
    nframes = 1;
    serial_run(20);
    check("R8 response had started", 90'(rx_oe[18]), 90'(1));
    check("R8 abort on load rise", 90'(sdo_oe), 90'(0));
    nframes = 0;
    serial_run(3);
    check("R8 no leftover drive", 90'({rx_oe[0], rx_oe[1], rx_oe[2]}), 90'(0));

    // R11: writes accepted with standby bit cleared
    frames[0] = {1'b0, 5'd0, 10'h180};
    frames[1] = {1'b0, 5'd1, 10'h111};
    nframes = 2;
    serial_run(32);
    check("R11 standby control written", 90'(ctrl), 90'(10'h180));
    check("R11 write while standby", 90'(gain), 90'(10'h111));

    // R6: soft reset through control bit 0
    frames[0] = {1'b0, 5'd0, 10'h381};
    nframes = 1;
    serial_run(16);
    check("R6 soft reset restores defaults", all_regs(), DEFS);
    frames[0] = {1'b1, 5'd0, 10'h000};
    frames[1] = FILL;
    nframes = 2;
    serial_run(34);
    check("R6 bit 0 reads zero", 90'(resp(17)), 90'({6'b0, 10'h380}));

    // R7: hardware reset mid-life
    frames[0] = {1'b0, 5'd10, 10'h200};
    nframes = 1;
    serial_run(16);
    check("R1 timing 2 written", 90'(t2), 90'(10'h200));
    rst_n = 1'b0;
    tick(3);
    check("R7 hardware reset defaults", all_regs(), DEFS);
    rst_n = 1'b1;
    tick(3);

    finish_run();
  end
endmodule